// File: doc/BRIEF.md
# History-Dependent Delay Channel

The block is a cycle-level model of a binary delay channel whose delay is not fixed. Each change seen on the input is scheduled to appear on the output some cycles later. The number of cycles comes from a small delay table indexed by the distance, in cycles, between the input change and a reference instant taken from the channel's own recent output history. A scheduled change that would land no later than its reference cancels against the newest pending change, so short pulses can vanish, shrink or be reshaped.

A mode input picks between two ways of choosing the reference. In forgetful mode the reference is the newest change that still exists: the newest pending change, or the last change the output actually made. In history-keeping mode the reference is the landing time computed for the most recent accepted input change, even when that change was later annihilated. A parameter selects the delay shape: a saturating ramp or the two-level inertial form. The block is used in timing and glitch-propagation models, where the output of one channel feeds a gate or another channel.

Top module: `shist_channel`

## Requirements
- R1: While rst_ni is low and after its release, dout_o equals INIT_VAL (default 0), nothing is pending, and with a constant input dout_o never changes.
- R2: din_i is sampled on every rising clk_i edge. An input transition exists only where the sample differs from the previous one. A transition whose value equals the newest value on the output list (the newest pending value, or dout_o if nothing is pending) has no effect.
- R3: A transition sampled at edge t and given delay d (d of at least 1) changes dout_o at edge t+d, visible right after that edge and not before. When a pending change falls due on the same edge as a new input sample, the change is applied first and the sample is judged against the state that results.
- R4: The delay uses T = t minus the reference instant, clamped to [T_LO, T_HI] (defaults -8 and 0). The ramp shape (SHAPE=0, default) gives min(D_HI, max(D_LO, D_HI+T)) with D_HI=6 and D_LO=1. A missing reference uses the limit, the value at T_HI.
- R5: If t+d is not later than the reference instant, or not later than the newest pending change, that newest pending change is removed and nothing is added. With nothing pending, the output list is left as it is.
- R6: With keep_hist_i=0 (forgetful), the reference is the newest pending change if one exists, and otherwise the edge of the last change of dout_o.
- R7: With keep_hist_i=1 (history-keeping), the reference is t+d of the most recent transition not ignored under R2, whether that change was kept or annihilated.
- R8: With the inertial shape (SHAPE=1, D_HI=5, KNEE=-2, delay -KNEE for T not above KNEE, and D_HI otherwise), an isolated input pulse of width w up to KNEE+D_HI = 3 cycles leaves no output pulse. A longer pulse comes out with the same width w and a delay of D_HI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; one cycle is the model's time unit |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 1 | Channel input |
| keep_hist_i | input | 1 | 0: forgetful reference; 1: history-keeping reference |
| dout_o | output | 1 | Channel output |

## Verification
On a single edge a pending change can fall due while a new input transition is being judged. The order of these two actions decides both the reference and the newest output-list value. The bench provokes this by sweeping two-pulse trains over every width and gap from 1 to 6 cycles in both modes, which repeatedly lands input edges exactly on a due cycle. The inertial check includes the width-5 case, where the falling input meets the rising output on the same edge. An independent event-list model in the bench judges the output on every cycle.

// File: rtl/shc_pkg.sv
`timescale 1ns/1ps
package shc_pkg;
  localparam int SHAPE_RAMP  = 0;
  localparam int SHAPE_INERT = 1;

  typedef enum logic {HIST_FORGET = 1'b0, HIST_KEEP = 1'b1} hist_mode_e;

  // delay for a given clamped time difference
  function automatic int dly_at(int shape, int t, int d_hi, int d_lo, int knee);
    int v;
    if (shape == SHAPE_INERT) begin
      v = (t <= knee) ? -knee : d_hi;
    end else begin
      v = d_hi + t;
      if (v < d_lo) v = d_lo;
      if (v > d_hi) v = d_hi;
    end
    return v;
  endfunction
endpackage

// File: rtl/shc_delay_lut.sv
`timescale 1ns/1ps
module shc_delay_lut
  import shc_pkg::*;
#(
  parameter int SHAPE  = SHAPE_RAMP,
  parameter int T_LO   = -8,
  parameter int T_HI   = 0,
  parameter int D_HI   = 6,
  parameter int D_LO   = 1,
  parameter int KNEE   = -2,
  parameter int TIME_W = 32,
  parameter int DW     = 3
) (
  input  logic signed [TIME_W:0] diff_i,
  input  logic                   ref_ok_i,
  output logic [DW-1:0]          dly_o
);
  localparam int N  = T_HI - T_LO + 1;
  localparam int IW = (N > 1) ? $clog2(N) : 1;
  localparam logic signed [TIME_W:0] LO_S = (TIME_W+1)'(T_LO);
  localparam logic signed [TIME_W:0] HI_S = (TIME_W+1)'(T_HI);

  logic [DW-1:0] tbl [N];
  logic [IW-1:0] idx;

  for (genvar g = 0; g < N; g++) begin : g_tbl
    assign tbl[g] = DW'(dly_at(SHAPE, T_LO + g, D_HI, D_LO, KNEE));
  end

  always_comb begin
    if (!ref_ok_i || diff_i >= HI_S) idx = IW'(N - 1);
    else if (diff_i <= LO_S)         idx = '0;
    else                             idx = IW'(diff_i - LO_S);
  end

  assign dly_o = tbl[idx];
endmodule

// File: rtl/shc_event_q.sv
`timescale 1ns/1ps
module shc_event_q #(
  parameter int DEPTH  = 4,
  parameter int TIME_W = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = PW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pop_i,
  input  logic              push_i,
  input  logic              drop_i,
  input  logic [TIME_W-1:0] t_i,
  input  logic              v_i,
  output logic [CW-1:0]     cnt_o,
  output logic [TIME_W-1:0] head_t_o,
  output logic              head_v_o,
  output logic [CW-1:0]     left_o,
  output logic [TIME_W-1:0] tail_t_o,
  output logic              tail_v_o
);
  logic [TIME_W-1:0] tq [DEPTH];
  logic [DEPTH-1:0]  vq;
  logic [PW-1:0]     hd_q, hd1, tl1, wr;
  logic [CW-1:0]     cnt_q, cnt1;

  // pop is applied before push/drop within the same edge
  assign hd1 = hd_q + PW'(pop_i);
  assign cnt1 = cnt_q - CW'(pop_i);
  assign tl1 = hd1 + PW'(cnt1 - CW'(1));
  assign wr  = hd1 + PW'(cnt1);

  assign cnt_o    = cnt_q;
  assign left_o   = cnt1;
  assign head_t_o = tq[hd_q];
  assign head_v_o = vq[hd_q];
  assign tail_t_o = tq[tl1];
  assign tail_v_o = vq[tl1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hd_q  <= '0;
      cnt_q <= '0;
    end else begin
      hd_q  <= hd1;
      cnt_q <= cnt1 + CW'(push_i) - CW'(drop_i);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      tq[wr] <= t_i;
      vq[wr] <= v_i;
    end
  end

  AST_Q_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH)) else $error("queue count overflow"); // R3
  AST_Q_ROOM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt1 < CW'(DEPTH))) else $error("push into full queue"); // R3
  AST_Q_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && cnt1 != '0) |-> (t_i > tail_t_o)) else $error("pending times not increasing"); // R5
  AST_Q_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_i |-> (cnt1 != '0 && !push_i)) else $error("bad annihilation"); // R5
endmodule

// File: rtl/shist_channel.sv
`timescale 1ns/1ps
module shist_channel
  import shc_pkg::*;
#(
  parameter logic INIT_VAL = 1'b0,
  parameter int   SHAPE    = SHAPE_RAMP,
  parameter int   D_HI     = 6,
  parameter int   D_LO     = 1,
  parameter int   KNEE     = -2,
  parameter int   T_LO     = -8,
  parameter int   T_HI     = 0,
  parameter int   DEPTH    = 4,
  parameter int   TIME_W   = 32
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic din_i,
  input  logic keep_hist_i,
  output logic dout_o
);
  localparam int DW = $clog2(D_HI + 1);
  localparam int CW = $clog2(DEPTH) + 1;

  hist_mode_e mode;
  logic [TIME_W-1:0] now_q, lo_t_q, r_q;
  logic              in_q, out_q, lo_ok_q, r_ok_q;

  logic [CW-1:0]     q_cnt, q_left;
  logic [TIME_W-1:0] q_head_t, q_tail_t;
  logic              q_head_v, q_tail_v;
  logic              q_pop, q_push, q_drop;

  logic              out_nx, lo_ok_nx, last_val, ev, act;
  logic [TIME_W-1:0] lo_t_nx, ref_t, sched;
  logic              ref_ok, later_ref, later_tail, add;
  logic signed [TIME_W:0] diff;
  logic [DW-1:0]     dly;

  assign mode = hist_mode_e'(keep_hist_i);

  // emission side
  assign q_pop    = (q_cnt != '0) && (q_head_t == now_q);
  assign out_nx   = q_pop ? q_head_v : out_q;
  assign lo_t_nx  = q_pop ? now_q : lo_t_q;
  assign lo_ok_nx = q_pop | lo_ok_q;

  // arrival side, judged against post-emission state
  assign last_val = (q_left != '0) ? q_tail_v : out_nx;
  assign ev       = (din_i != in_q);
  assign act      = ev && (din_i != last_val);

  always_comb begin
    if (mode == HIST_KEEP) begin
      ref_t  = r_q;
      ref_ok = r_ok_q;
    end else if (q_left != '0) begin
      ref_t  = q_tail_t;
      ref_ok = 1'b1;
    end else begin
      ref_t  = lo_t_nx;
      ref_ok = lo_ok_nx;
    end
  end

  assign diff = $signed({1'b0, now_q}) - $signed({1'b0, ref_t});

  shc_delay_lut #(
    .SHAPE(SHAPE), .T_LO(T_LO), .T_HI(T_HI), .D_HI(D_HI), .D_LO(D_LO),
    .KNEE(KNEE), .TIME_W(TIME_W), .DW(DW)
  ) u_lut (
    .diff_i  (diff),
    .ref_ok_i(ref_ok),
    .dly_o   (dly)
  );

  assign sched      = now_q + TIME_W'(dly);
  assign later_ref  = !ref_ok || (sched > ref_t);
  assign later_tail = (q_left == '0) || (sched > q_tail_t);
  assign add        = act && later_ref && later_tail;
  assign q_push     = add && (q_left < CW'(DEPTH));
  assign q_drop     = act && !add && (q_left != '0);

  shc_event_q #(.DEPTH(DEPTH), .TIME_W(TIME_W)) u_q (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pop_i   (q_pop),
    .push_i  (q_push),
    .drop_i  (q_drop),
    .t_i     (sched),
    .v_i     (din_i),
    .cnt_o   (q_cnt),
    .head_t_o(q_head_t),
    .head_v_o(q_head_v),
    .left_o  (q_left),
    .tail_t_o(q_tail_t),
    .tail_v_o(q_tail_v)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      now_q   <= '0;
      in_q    <= INIT_VAL;
      out_q   <= INIT_VAL;
      lo_t_q  <= '0;
      lo_ok_q <= 1'b0;
      r_q     <= '0;
      r_ok_q  <= 1'b0;
    end else begin
      now_q   <= now_q + TIME_W'(1);
      in_q    <= din_i;
      out_q   <= out_nx;
      lo_t_q  <= lo_t_nx;
      lo_ok_q <= lo_ok_nx;
      if (act) begin
        r_q    <= sched;
        r_ok_q <= 1'b1;
      end
    end
  end

  assign dout_o = out_q;

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_cnt == '0) |=> $stable(dout_o)) else $error("output moved with nothing due"); // R3
  AST_SCHED_AHEAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_push |-> (sched > now_q)) else $error("scheduled change not in future"); // R3
  AST_NO_EVENT_NO_GROWTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ev |=> (q_cnt <= $past(q_cnt))) else $error("queue grew without input change"); // R2
endmodule

// File: tb/sim_shist_channel.sv
`timescale 1ns/1ps
module sim_shist_channel;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic din = 1'b0;
  logic keep = 1'b0;
  logic dout0, dout1;

  always #5 clk = ~clk;

  shist_channel u0 (
    .clk_i(clk), .rst_ni(rst_ni), .din_i(din), .keep_hist_i(keep), .dout_o(dout0)
  );

  shist_channel #(.SHAPE(1), .D_HI(5), .KNEE(-2)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .din_i(din), .keep_hist_i(keep), .dout_o(dout1)
  );

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // event-list reference for u0 (ramp, depth 4)
  int m_now = 0;
  int mq_t [4];
  bit mq_v [4];
  int mq_n = 0;
  bit m_out = 1'b0, m_in = 1'b0;
  int m_lo_t = 0;
  bit m_lo_ok = 1'b0;
  int m_r = 0;
  bit m_r_ok = 1'b0;

  int mism = 0, fm_cyc = 0, fm_act = 0, fm_exp = 0;
  logic rec0 [64];
  logic rec1 [64];
  int rec_i = 0;

  function automatic int ramp_dly(int t);
    int v;
    if (t > 0) t = 0;
    if (t < -8) t = -8;
    v = 6 + t;
    if (v < 1) v = 1;
    return v;
  endfunction

  task automatic model_step(input bit d);
    bit lastv, rok;
    int rt, sched, tt;
    if (mq_n > 0 && mq_t[0] == m_now) begin
      m_out = mq_v[0];
      m_lo_t = m_now;
      m_lo_ok = 1'b1;
      for (int k = 0; k < 3; k++) begin mq_t[k] = mq_t[k+1]; mq_v[k] = mq_v[k+1]; end
      mq_n--;
    end
    lastv = (mq_n > 0) ? mq_v[mq_n-1] : m_out;
    if (d != m_in && d != lastv) begin
      if (keep) begin rt = m_r; rok = m_r_ok; end
      else if (mq_n > 0) begin rt = mq_t[mq_n-1]; rok = 1'b1; end
      else begin rt = m_lo_t; rok = m_lo_ok; end
      tt = rok ? (m_now - rt) : 1000;
      sched = m_now + ramp_dly(tt);
      if ((!rok || sched > rt) && (mq_n == 0 || sched > mq_t[mq_n-1])) begin
        if (mq_n < 4) begin mq_t[mq_n] = sched; mq_v[mq_n] = d; mq_n++; end
      end else if (mq_n > 0) begin
        mq_n--;
      end
      m_r = sched;
      m_r_ok = 1'b1;
    end
    m_in = d;
    m_now++;
  endtask

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick(input logic d);
    @(negedge clk);
    din = d;
    @(posedge clk);
    model_step(d);
    #1;
    if (dout0 !== m_out) begin
      if (mism == 0) begin fm_cyc = m_now - 1; fm_act = int'(dout0); fm_exp = int'(m_out); end
      mism++;
    end
    if (rec_i < 64) begin rec0[rec_i] = dout0; rec1[rec_i] = dout1; rec_i++; end
  endtask

  task automatic run(input logic d, input int n);
    for (int k = 0; k < n; k++) tick(d);
  endtask

  function automatic int ones1(input int a, input int b);
    int c = 0;
    for (int k = a; k <= b; k++) if (rec1[k] === 1'b1) c++;
    return c;
  endfunction

  function automatic int ones0(input int a, input int b);
    int c = 0;
    for (int k = a; k <= b; k++) if (rec0[k] === 1'b1) c++;
    return c;
  endfunction

  initial begin
    #1_500_000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(dout0 === 1'b0, "R1", "u0 output in reset", int'(dout0), 0);
    chk(dout1 === 1'b0, "R1", "u1 output in reset", int'(dout1), 0);
    rst_ni = 1'b1;

    // constant input: no events, output stays put
    rec_i = 0; mism = 0;
    run(1'b0, 30);
    chk(ones0(0, 29) == 0 && mism == 0, "R1", "quiet output after reset", ones0(0, 29), 0);
    chk(ones1(0, 29) == 0, "R2", "u1 quiet with no transitions", ones1(0, 29), 0);

    // R3/R4: isolated long pulse, limit delay 6, fall referenced to last output change
    rec_i = 0;
    run(1'b1, 8); run(1'b0, 30);
    chk(rec0[5] === 1'b0 && rec0[6] === 1'b1, "R3", "rise lands at edge +6", int'(rec0[6]), 1);
    chk(rec0[13] === 1'b1 && rec0[14] === 1'b0, "R6", "fall lands at edge 8+6", int'(rec0[14]), 0);

    // R4: intermediate delay, fall at T=-2 gets delay 4
    run(1'b0, 20);
    rec_i = 0;
    run(1'b1, 4); run(1'b0, 30);
    chk(ones0(0, 33) == 2 && rec0[6] === 1'b1 && rec0[8] === 1'b0, "R4", "pulse width from ramp", ones0(0, 33), 2);

    // R5: one-cycle pulse annihilated, both modes
    for (int m = 0; m < 2; m++) begin
      keep = m[0];
      run(1'b0, 20);
      rec_i = 0;
      run(1'b1, 1); run(1'b0, 30);
      chk(ones0(0, 30) == 0, "R5", "short pulse annihilated", ones0(0, 30), 0);
    end

    // R6 vs R7: after an annihilation the next rise uses different references
    for (int m = 0; m < 2; m++) begin
      keep = m[0];
      run(1'b0, 20);
      rec_i = 0;
      run(1'b1, 2); run(1'b0, 1); run(1'b1, 17); run(1'b0, 30);
      if (m == 0)
        chk(rec0[8] === 1'b0 && rec0[9] === 1'b1, "R6", "forgetful rise at edge 9", int'(rec0[9]), 1);
      else
        chk(rec0[7] === 1'b0 && rec0[8] === 1'b1, "R7", "history rise at edge 8", int'(rec0[8]), 1);
      chk(rec0[25] === 1'b1 && rec0[26] === 1'b0, m ? "R7" : "R6", "fall at edge 26", int'(rec0[26]), 0);
    end

    // R8: inertial shape on u1, widths 1..8
    keep = 1'b0;
    for (int w = 1; w <= 8; w++) begin
      run(1'b0, 20);
      rec_i = 0;
      run(1'b1, w); run(1'b0, 30);
      if (w <= 3)
        chk(ones1(0, w + 29) == 0, "R8", $sformatf("width %0d filtered", w), ones1(0, w + 29), 0);
      else
        chk(ones1(0, w + 29) == w && rec1[4] === 1'b0 && rec1[5] === 1'b1, "R8",
            $sformatf("width %0d forwarded", w), ones1(0, w + 29), w);
    end

    // two-pulse sweeps against the event-list reference (R2 ignore rule, R5 annihilation)
    for (int m = 0; m < 2; m++) begin
      keep = m[0];
      for (int w1 = 1; w1 <= 6; w1++)
        for (int g = 1; g <= 6; g++)
          for (int w2 = 1; w2 <= 6; w2++) begin
            run(1'b0, 16);
            mism = 0;
            run(1'b1, w1); run(1'b0, g); run(1'b1, w2); run(1'b0, 16);
            chk(mism == 0, m ? "R7" : "R6",
                $sformatf("train %0d/%0d/%0d edge %0d (R2 R5)", w1, g, w2, fm_cyc), fm_act, fm_exp);
          end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule